// File: doc/BRIEF.md
# Host Read-Response Message Receiver

This block sits on the host side of a byte-oriented SPI link to a slave processor. The slave signals pending response data through an active-low request line. The block starts a read cycle when that line is low while it is idle. It then pulls bytes one at a time from a byte transfer engine and turns them into framed messages on an output stream. The request line can only be observed once a whole byte has been transferred, so the block cannot see a short high pulse between two messages. It therefore treats a line that stays low as a back-to-back read. When a filler 0x00 byte shows up where an opcode is expected, the block drops it.

The first non-null byte of each message is its opcode. The opcode is looked up in a small programmable table that gives the total message length, opcode included. The block forwards exactly that many bytes, marking the first with a start flag and the last with an end flag. After the last byte, the request level sampled with that byte decides the next step. If it is high, the block issues a stop and returns to idle. If it is still low, the block reads the next message within the same cycle. An unknown opcode, or a second null in a row, raises an error pulse and closes the cycle.

Top module: `rr_host_rx`

## Requirements
- R1: After synchronous reset, byte_req, bus_start, bus_stop, out_valid, err_null and err_unknown are all 0, and all length-table entries are empty.
- R2: While idle with irq_n high, nothing is issued. When irq_n is low in idle, bus_start is high for exactly one cycle, and byte_req rises in the following cycle and stays high until the cycle ends.
- R3: A non-zero byte received in the opcode slot whose table length L is non-zero is forwarded with out_sop=1. Exactly L bytes are forwarded in total, and the L-th carries out_eop=1. When L is 1, out_sop and out_eop are both set on the same beat.
- R4: One 0x00 byte in the opcode slot is discarded without any output, and the next byte is taken as the opcode.
- R5: A second consecutive 0x00 in the opcode slot produces a one-cycle err_null pulse, is not forwarded, and ends the cycle with bus_stop.
- R6: If irq_n is high at the acknowledge of a message's last byte, bus_stop is high for one cycle in the next cycle, after which byte_req stays low while irq_n is high.
- R7: If irq_n is low at the acknowledge of a message's last byte, the cycle continues with no bus_stop or bus_start. The next byte is treated as an opcode, and one null byte is again allowed.
- R8: An opcode with no table entry, or whose matching entries all hold length 0, produces a one-cycle err_unknown pulse. The opcode is not forwarded, and the cycle ends with bus_stop.
- R9: A cfg_we pulse writes {cfg_opcode, cfg_len} into entry cfg_idx, replacing the old content. When several entries hold the same opcode with non-zero length, the lowest index is used.
- R10: Bytes after the opcode are forwarded unchanged, including 0x00. irq_n is ignored on every byte except a message's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Active-low request line from the slave |
| byte_rx | input | 8 | Byte received by the transfer engine |
| byte_ack | input | 1 | One-cycle strobe: byte_rx holds a completed byte |
| byte_req | output | 1 | Asks the engine for the next byte |
| bus_start | output | 1 | One-cycle request for a start condition plus chip address |
| bus_stop | output | 1 | One-cycle request for a stop condition |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Table entry index |
| cfg_opcode | input | 8 | Opcode stored in the entry |
| cfg_len | input | LEN_W | Total message length in bytes (0 = unusable) |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sop | output | 1 | Beat is the opcode |
| out_eop | output | 1 | Beat is the last byte of the message |
| err_null | output | 1 | Two nulls in a row in the opcode slot |
| err_unknown | output | 1 | Opcode not resolvable by the table |

## Verification
The hardest situation to reach is a message boundary crossed with irq_n held low. Here the next byte must be re-classified as an opcode, the null allowance must be re-armed, and no stop or start may appear. The vector walk drives several messages back to back with the line low, inserting a single null between some of them and two nulls at the end. It also mixes in a body byte of 0x00 and a high irq_n in mid-message to show that neither affects framing.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] NULL_BYTE = '0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_OPC,
        S_BODY,
        S_STOP
    } rr_state_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              sop;
        logic              eop;
    } rr_beat_t;

    function automatic logic is_null(input logic [BYTE_W-1:0] b);
        return b == NULL_BYTE;
    endfunction

endpackage

// File: rtl/rr_len_table.sv
module rr_len_table
    import rr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 6,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BYTE_W-1:0] cfg_opcode,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [BYTE_W-1:0] key,
    output logic              hit,
    output logic [LEN_W-1:0]  hit_len
);

    logic              ent_vld [DEPTH];
    logic [BYTE_W-1:0] ent_opc [DEPTH];
    logic [LEN_W-1:0]  ent_len [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[g] <= 1'b0;
                ent_opc[g] <= '0;
                ent_len[g] <= '0;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                ent_vld[g] <= 1'b1;
                ent_opc[g] <= cfg_opcode;
                ent_len[g] <= cfg_len;
            end
        end
    end

    // Scan from the top so the lowest matching index wins.
    always_comb begin
        hit     = 1'b0;
        hit_len = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_vld[i] && ent_opc[i] == key && ent_len[i] != '0) begin
                hit     = 1'b1;
                hit_len = ent_len[i];
            end
        end
    end

    p_hit_len_r9: assert property (@(posedge clk) disable iff (rst)
        hit |-> hit_len != '0);

endmodule

// File: rtl/rr_seq.sv
module rr_seq
    import rr_pkg::*;
#(
    parameter int LEN_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n,
    input  logic [BYTE_W-1:0] byte_rx,
    input  logic              byte_ack,
    input  logic              hit,
    input  logic [LEN_W-1:0]  hit_len,
    output logic              byte_req,
    output logic              bus_start,
    output logic              bus_stop,
    output rr_beat_t          beat,
    output logic              err_null,
    output logic              err_unknown
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    rr_state_e        state, state_n;
    logic             null_seen, null_n;
    logic [LEN_W-1:0] remain, remain_n;
    rr_beat_t         beat_n;
    logic             en_n, eu_n;

    assign byte_req  = (state == S_OPC) || (state == S_BODY);
    assign bus_start = (state == S_START);
    assign bus_stop  = (state == S_STOP);

    always_comb begin
        state_n  = state;
        null_n   = null_seen;
        remain_n = remain;
        beat_n   = '0;
        en_n     = 1'b0;
        eu_n     = 1'b0;
        unique case (state)
            S_IDLE: if (!irq_n) state_n = S_START;
            S_START: begin
                null_n  = 1'b0;
                state_n = S_OPC;
            end
            S_OPC: if (byte_ack) begin
                if (is_null(byte_rx)) begin
                    if (null_seen) begin
                        en_n    = 1'b1;
                        state_n = S_STOP;
                    end else begin
                        null_n = 1'b1;
                    end
                end else if (!hit) begin
                    eu_n    = 1'b1;
                    state_n = S_STOP;
                end else begin
                    null_n   = 1'b0;
                    beat_n   = '{valid: 1'b1, data: byte_rx, sop: 1'b1,
                                 eop: (hit_len == ONE)};
                    remain_n = hit_len - ONE;
                    if (hit_len == ONE) state_n = irq_n ? S_STOP : S_OPC;
                    else                state_n = S_BODY;
                end
            end
            S_BODY: if (byte_ack) begin
                beat_n   = '{valid: 1'b1, data: byte_rx, sop: 1'b0,
                             eop: (remain == ONE)};
                remain_n = remain - ONE;
                if (remain == ONE) begin
                    null_n  = 1'b0;
                    state_n = irq_n ? S_STOP : S_OPC;
                end
            end
            S_STOP:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            null_seen   <= 1'b0;
            remain      <= '0;
            beat        <= '0;
            err_null    <= 1'b0;
            err_unknown <= 1'b0;
        end else begin
            state       <= state_n;
            null_seen   <= null_n;
            remain      <= remain_n;
            beat        <= beat_n;
            err_null    <= en_n;
            err_unknown <= eu_n;
        end
    end

    p_start_then_req_r2: assert property (@(posedge clk) disable iff (rst)
        bus_start |=> byte_req && !bus_start);
    p_stop_then_idle_r6: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !byte_req && !bus_stop);
    p_sop_nonnull_r4: assert property (@(posedge clk) disable iff (rst)
        beat.valid && beat.sop |-> beat.data != NULL_BYTE);
    p_events_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({beat.valid, err_null, err_unknown}));
    p_null_err_src_r5: assert property (@(posedge clk) disable iff (rst)
        err_null |-> $past(byte_ack) && $past(byte_rx) == NULL_BYTE);
    p_err_stops_r8: assert property (@(posedge clk) disable iff (rst)
        (err_null || err_unknown) |-> bus_stop);
    p_body_len_r3: assert property (@(posedge clk) disable iff (rst)
        state == S_BODY |-> remain != '0);

endmodule

// File: rtl/rr_host_rx.sv
module rr_host_rx
    import rr_pkg::*;
#(
    parameter int TBL_DEPTH = 8,
    parameter int LEN_W     = 6,
    localparam int IDX_W    = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n,
    input  logic [BYTE_W-1:0] byte_rx,
    input  logic              byte_ack,
    output logic              byte_req,
    output logic              bus_start,
    output logic              bus_stop,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [BYTE_W-1:0] cfg_opcode,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              err_null,
    output logic              err_unknown
);

    logic             hit;
    logic [LEN_W-1:0] hit_len;
    rr_beat_t         beat;

    rr_len_table #(.DEPTH(TBL_DEPTH), .LEN_W(LEN_W)) tbl_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_opcode (cfg_opcode),
        .cfg_len    (cfg_len),
        .key        (byte_rx),
        .hit        (hit),
        .hit_len    (hit_len)
    );

    rr_seq #(.LEN_W(LEN_W)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .irq_n       (irq_n),
        .byte_rx     (byte_rx),
        .byte_ack    (byte_ack),
        .hit         (hit),
        .hit_len     (hit_len),
        .byte_req    (byte_req),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .beat        (beat),
        .err_null    (err_null),
        .err_unknown (err_unknown)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_sop   = beat.sop;
    assign out_eop   = beat.eop;

    p_no_start_stop_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_start && bus_stop));
    p_no_beat_in_stop_r6: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !out_valid);

endmodule

// File: tb/rr_host_rx_tb_top.sv
module rr_host_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq_n = 1'b1;
    logic [7:0] byte_rx = '0;
    logic byte_ack = 1'b0;
    logic byte_req, bus_start, bus_stop;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [7:0] cfg_opcode = '0;
    logic [5:0] cfg_len = '0;
    logic out_valid, out_sop, out_eop, err_null, err_unknown;
    logic [7:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rr_host_rx dut_i (
        .clk(clk), .rst(rst), .irq_n(irq_n), .byte_rx(byte_rx), .byte_ack(byte_ack),
        .byte_req(byte_req), .bus_start(bus_start), .bus_stop(bus_stop),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_opcode(cfg_opcode), .cfg_len(cfg_len),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .err_null(err_null), .err_unknown(err_unknown)
    );

    // {data[14:7], irq[6], valid[5], sop[4], eop[3], err_null[2], err_unknown[1], stop[0]}
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h11, 7'b0110000},
        {8'hA5, 7'b1100000},
        {8'h00, 7'b1101001},
        {8'h00, 7'b0000000},
        {8'h22, 7'b0111000},
        {8'h00, 7'b0000000},
        {8'h33, 7'b0110000},
        {8'h7E, 7'b0101000},
        {8'h00, 7'b0000000},
        {8'h00, 7'b0000101},
        {8'h44, 7'b1000011},
        {8'h99, 7'b1000011},
        {8'h22, 7'b1111001}
    };
    string vtag [NVEC] = '{"R3", "R10", "R6", "R4", "R9", "R7", "R7", "R7",
                           "R4", "R5", "R8", "R8", "R6"};

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [7:0] opc, input logic [5:0] len);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_opcode = opc; cfg_len = len;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Waits for a byte request, then completes one transfer with the given
    // request level; returns at the falling edge after the acknowledge edge.
    task automatic xfer(input logic [7:0] data, input logic irq);
        irq_n = 1'b0;
        while (byte_req !== 1'b1) @(negedge clk);
        irq_n = irq; byte_rx = data; byte_ack = 1'b1;
        @(negedge clk);
        byte_ack = 1'b0;
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "byte_req", 32'(byte_req), 0);
        check("R1", "bus_start", 32'(bus_start), 0);
        check("R1", "bus_stop", 32'(bus_stop), 0);
        check("R1", "outputs", {29'd0, out_valid, err_null, err_unknown}, 0);

        // R9 table load, duplicate 0x22 at a higher index
        cfg_write(0, 8'h11, 6'd3);
        cfg_write(1, 8'h22, 6'd1);
        cfg_write(2, 8'h33, 6'd2);
        cfg_write(3, 8'h44, 6'd0);
        cfg_write(4, 8'h22, 6'd5);

        // R2 idle with irq_n high issues nothing
        irq_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (bus_start || byte_req) check("R2", "idle activity", {bus_start, byte_req}, 0);
        end
        check("R2", "idle quiet", {30'd0, bus_start, byte_req}, 0);
        irq_n = 1'b0;
        @(negedge clk);
        check("R2", "bus_start pulse", 32'(bus_start), 1);
        check("R2", "no req during start", 32'(byte_req), 0);
        @(negedge clk);
        check("R2", "bus_start drops", 32'(bus_start), 0);
        check("R2", "byte_req rises", 32'(byte_req), 1);

        // vector walk
        for (int v = 0; v < NVEC; v++) begin
            logic [14:0] e;
            e = VEC[v];
            xfer(e[14:7], e[6]);
            check(vtag[v], $sformatf("vec%0d flags", v),
                  {26'd0, out_valid, out_sop, out_eop, err_null, err_unknown, bus_stop},
                  {26'd0, e[5:0]});
            if (e[5]) check(vtag[v], $sformatf("vec%0d data", v), 32'(out_data), 32'(e[14:7]));
        end

        // R6 after stop with irq_n high: idle, no request
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R6", "idle after stop", {30'd0, byte_req, bus_start}, 0);

        // R9 rewrite entry 0: 0x11 now two bytes long
        cfg_write(0, 8'h11, 6'd2);
        xfer(8'h11, 1'b0);
        check("R9", "rewritten sop", {29'd0, out_valid, out_sop, out_eop}, 3'b110);
        xfer(8'h55, 1'b1);
        check("R9", "rewritten eop", {29'd0, out_valid, out_sop, out_eop}, 3'b101);
        check("R6", "stop after rewrite", 32'(bus_stop), 1);
        check("R10", "body data", 32'(out_data), 32'h55);

        // R1 reset mid-cycle clears everything
        xfer(8'h33, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        irq_n = 1'b1;
        @(negedge clk);
        check("R1", "reset mid-cycle", {29'd0, byte_req, out_valid, bus_stop}, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule